// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel behind a byte-wide register interface. It has two registers. A control register at offset 3 takes mode words, counter-latch commands and read-back commands. A data register at offset 0 takes the reload value and returns either latched bytes or the live count. The block counts one step on each clock cycle in which `cntEn` is high. An integration sets the tick rate by strobing that input at the wanted input frequency.

Two operating behaviours are built. The first is a periodic square wave. It reloads itself and raises a one-cycle `tickIrq` strobe on every rising edge of the output, which makes it suitable as a periodic scheduler interrupt. The second is a one-shot countdown, used for calibration: the output stays low until the count runs out. Software can freeze the count, the status or both through a read-back command. It can also poll the null-count status flag to learn when a newly written value has reached the counter.

Top module: `pit_channel`

## Requirements
- R1: After reset `outLevel` and `tickIrq` are 0, and a status read-back returns 0x70 (output low, null count set, low-then-high access, mode 000).
- R2: A byte written to offset 3 with bits 7:6 = 00 addresses the channel. Bits 7:6 = 01 or 10 address absent channels and are ignored. For an accepted mode word, bits 5:4 give the access mode (01 low byte only, 10 high byte only, 11 low then high) and bits 3:1 give the operating mode: x11 is square wave and any other value is one-shot. Accepting a mode word stops counting and holds `outLevel` high in square-wave mode and low in one-shot mode.
- R3: Count bytes are written to offset 0 according to the access mode. Low-only access zeroes the high byte and high-only access zeroes the low byte. A value of 0 means 65536 steps.
- R4: Status bit 6 (null count) is set by a mode word and by every completed count write. It clears on the enabled step that moves the written value into the counter.
- R5: The counter, `outLevel` and `tickIrq` change only on clock edges where `cntEn` is high, apart from the effect of a mode word.
- R6: In one-shot mode the first enabled step after a complete write loads the value N. `outLevel` rises on the N-th step after the load and then stays high.
- R7: In square-wave mode with N >= 2, `outLevel` is high for ceil(N/2) steps and low for floor(N/2) steps, and the pattern repeats without software action.
- R8: `tickIrq` is high for exactly one cycle on each rising edge of `outLevel` while the channel is counting. A mode word never produces a tick.
- R9: In square-wave mode a count written while the channel runs takes effect only at the end of the current period.
- R10: A read-back command has bits 7:6 = 11 and bit 1 = 1 (channel select); bit 5 = 0 latches the count and bit 4 = 0 latches the status. With both latched, the next data read returns the status, and the following reads return the count bytes in access-mode order.
- R11: A latched count stays unchanged until all of its bytes have been read, even while counting continues. A further latch request of the same kind during that time is ignored.
- R12: A control byte with bits 7:4 = 0000 latches the count, just as a read-back command does.
- R13: With nothing latched, data reads return the live count bytes in access-mode order.
- R14: The status byte holds `outLevel` in bit 7, null count in bit 6, the access mode in bits 5:4, the operating mode in bits 3:1, and 0 in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count-step enable; one step per high cycle |
| addr | input | 2 | Register offset: 0 data, 3 control |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Read strobe; advances the read sequence |
| rdData | output | 8 | Read byte, valid in the cycle `rdEn` is high |
| outLevel | output | 1 | Timer output level |
| tickIrq | output | 1 | One-cycle interrupt strobe on each output rise |

## Verification
The hardest situation to reach is a square-wave period boundary at which a newly written count is pending. At that point the null-count flag, the reload and the output phase all change on the same step. The bench stops `cntEn` right after a tick, writes a new count, checks that null count is still set, and then resumes counting. It measures the remainder of the old period and the length of the new one in enabled steps. The latch-hold case is reached the same way: the bench latches, keeps counting, and issues a second latch before reading, so that a wrongly accepted second latch would show up in the low byte.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LOW   = 2'b01,
    ACC_HIGH  = 2'b10,
    ACC_PAIR  = 2'b11
  } accMode_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_LATCH_LO,
    RD_LATCH_HI,
    RD_LIVE_LO,
    RD_LIVE_HI
  } rdSrc_t;

  typedef enum logic [1:0] {
    CM_LOW,
    CM_HIGH,
    CM_PAIR
  } commitKind_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic        newMode;
    logic        holdLow;
    logic        commit;
    commitKind_t commitKind;
    logic        loadCounter;
    logic        countStep;
    logic        latchCount;
    logic        latchStatus;
    rdSrc_t      rdSrc;
  } pitStrobe_t;

  function automatic logic isSquare(input logic [2:0] mode);
    return (mode == 3'b011) || (mode == 3'b111);
  endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 3,
  parameter int DATA_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              periodEnd,
  output pitStrobe_t        strb,
  output accMode_t          accMode,
  output logic [2:0]        opMode,
  output logic              nullCount,
  output logic              running
);

  logic ctrlWr, dataWr, dataRd;
  logic isModeWord, isLatchCmd, rbCh0;
  logic wantCount, wantStatus;
  logic wrHi, rdHi, rdHiNext;
  logic countHeld, statusHeld, countDone, statusDone;
  logic pendValid;
  logic unusedBits;

  assign ctrlWr = wrEn && (addr == ADDR_W'(CTRL_ADDR));
  assign dataWr = wrEn && (addr == ADDR_W'(DATA_ADDR));
  assign dataRd = rdEn && (addr == ADDR_W'(DATA_ADDR));

  assign isModeWord = ctrlWr && (wrData[7:6] == 2'b00) && (wrData[5:4] != 2'b00);
  assign isLatchCmd = ctrlWr && (wrData[7:6] == 2'b00) && (wrData[5:4] == 2'b00);
  assign rbCh0      = ctrlWr && (wrData[7:6] == 2'b11) && wrData[1];
  assign unusedBits = ^{wrData[3:2], wrData[0], wrData[DATA_W-1:8]};

  assign wantCount  = (isLatchCmd || (rbCh0 && !wrData[5])) && !countHeld;
  assign wantStatus = rbCh0 && !wrData[4] && !statusHeld;

  // write side and counter scheduling
  always_comb begin
    strb             = '0;
    strb.newMode     = isModeWord;
    strb.holdLow     = dataWr && (accMode == ACC_PAIR) && !wrHi;
    strb.commit      = dataWr && ((accMode != ACC_PAIR) || wrHi);
    case (accMode)
      ACC_LOW:  strb.commitKind = CM_LOW;
      ACC_HIGH: strb.commitKind = CM_HIGH;
      default:  strb.commitKind = CM_PAIR;
    endcase
    strb.loadCounter = cntEn && pendValid && !isModeWord &&
                       (!running || !isSquare(opMode) || periodEnd);
    strb.countStep   = cntEn && running && !strb.loadCounter && !isModeWord;
    strb.latchCount  = wantCount;
    strb.latchStatus = wantStatus;
    strb.rdSrc       = RD_NONE;
    rdHiNext         = rdHi;
    countDone        = 1'b0;
    statusDone       = 1'b0;
    if (dataRd) begin
      if (statusHeld) begin
        strb.rdSrc = RD_STATUS;
        statusDone = 1'b1;
      end else begin
        case (accMode)
          ACC_LOW: begin
            strb.rdSrc = countHeld ? RD_LATCH_LO : RD_LIVE_LO;
            countDone  = countHeld;
          end
          ACC_HIGH: begin
            strb.rdSrc = countHeld ? RD_LATCH_HI : RD_LIVE_HI;
            countDone  = countHeld;
          end
          default: begin
            if (rdHi) begin
              strb.rdSrc = countHeld ? RD_LATCH_HI : RD_LIVE_HI;
              countDone  = countHeld;
              rdHiNext   = 1'b0;
            end else begin
              strb.rdSrc = countHeld ? RD_LATCH_LO : RD_LIVE_LO;
              rdHiNext   = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accMode    <= ACC_PAIR;
      opMode     <= 3'b000;
      wrHi       <= 1'b0;
      rdHi       <= 1'b0;
      countHeld  <= 1'b0;
      statusHeld <= 1'b0;
      nullCount  <= 1'b1;
      running    <= 1'b0;
      pendValid  <= 1'b0;
    end else if (isModeWord) begin
      accMode    <= accMode_t'(wrData[5:4]);
      opMode     <= wrData[3:1];
      wrHi       <= 1'b0;
      rdHi       <= 1'b0;
      countHeld  <= 1'b0;
      statusHeld <= 1'b0;
      nullCount  <= 1'b1;
      running    <= 1'b0;
      pendValid  <= 1'b0;
    end else begin
      if (strb.holdLow) wrHi <= 1'b1;
      else if (strb.commit) wrHi <= 1'b0;
      if (strb.commit) begin
        pendValid <= 1'b1;
        nullCount <= 1'b1;
      end else if (strb.loadCounter) begin
        pendValid <= 1'b0;
        nullCount <= 1'b0;
      end
      if (strb.loadCounter) running <= 1'b1;
      rdHi <= rdHiNext;
      if (wantCount) countHeld <= 1'b1;
      else if (countDone) countHeld <= 1'b0;
      if (wantStatus) statusHeld <= 1'b1;
      else if (statusDone) statusHeld <= 1'b0;
    end
  end

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pitStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  accMode_t          accMode,
  input  logic [2:0]        opMode,
  input  logic              nullCount,
  input  logic              running,
  output logic              periodEnd,
  output logic [DATA_W-1:0] rdData,
  output logic              outLevel,
  output logic              tickIrq
);

  logic [CNT_W-1:0]  count, activeReload, pendCount, latchedCount;
  logic [DATA_W-1:0] lowHold, statusLatch;
  logic              tcHit, outPrev, squareMode;
  logic [CNT_W:0]    effCount, effHalf;

  assign squareMode = isSquare(opMode);
  assign periodEnd  = (count == CNT_W'(1));
  // a stored zero stands for the full range
  assign effCount   = {count == '0, count};
  assign effHalf    = {activeReload == '0, activeReload} >> 1;

  always_comb begin
    if (!running) outLevel = squareMode;
    else if (squareMode) outLevel = (effCount > effHalf);
    else outLevel = tcHit;
  end

  assign tickIrq = outLevel && !outPrev && running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count        <= '0;
      activeReload <= '0;
      tcHit        <= 1'b0;
    end else if (strb.newMode) begin
      tcHit <= 1'b0;
    end else if (strb.loadCounter) begin
      count        <= pendCount;
      activeReload <= pendCount;
      tcHit        <= 1'b0;
    end else if (strb.countStep) begin
      if (squareMode && periodEnd) count <= activeReload;
      else count <= count - CNT_W'(1);
      if (!squareMode && periodEnd) tcHit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCount <= '0;
      lowHold   <= '0;
    end else begin
      if (strb.holdLow) lowHold <= wrData;
      if (strb.commit) begin
        case (strb.commitKind)
          CM_LOW:  pendCount <= {{DATA_W{1'b0}}, wrData};
          CM_HIGH: pendCount <= {wrData, {DATA_W{1'b0}}};
          default: pendCount <= {wrData, lowHold};
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedCount <= '0;
      statusLatch  <= '0;
      outPrev      <= 1'b0;
    end else begin
      outPrev <= outLevel;
      if (strb.latchCount) latchedCount <= count;
      if (strb.latchStatus)
        statusLatch <= DATA_W'({outLevel, nullCount, accMode, opMode, 1'b0});
    end
  end

  always_comb begin
    case (strb.rdSrc)
      RD_STATUS:   rdData = statusLatch;
      RD_LATCH_LO: rdData = latchedCount[DATA_W-1:0];
      RD_LATCH_HI: rdData = latchedCount[CNT_W-1:DATA_W];
      RD_LIVE_LO:  rdData = count[DATA_W-1:0];
      RD_LIVE_HI:  rdData = count[CNT_W-1:DATA_W];
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 3,
  parameter int DATA_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              outLevel,
  output logic              tickIrq
);

  pitStrobe_t strb;
  accMode_t   accMode;
  logic [2:0] opMode;
  logic       nullCount, running, periodEnd;

  pit_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .periodEnd(periodEnd), .strb(strb),
    .accMode(accMode), .opMode(opMode), .nullCount(nullCount), .running(running)
  );

  pit_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .accMode(accMode),
    .opMode(opMode), .nullCount(nullCount), .running(running),
    .periodEnd(periodEnd), .rdData(rdData), .outLevel(outLevel), .tickIrq(tickIrq)
  );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cntEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              outLevel,
  input logic              tickIrq
);

  logic modeWr;
  assign modeWr = wrEn && (addr == ADDR_W'(CTRL_ADDR)) &&
                  (wrData[7:6] == 2'b00) && (wrData[5:4] != 2'b00);

  // R8: a tick never lasts two cycles
  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |=> !tickIrq);

  // R5: a tick only follows an enabled count step
  p_tick_after_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |-> $past(cntEn));

  // R5: without enable or writes the output holds
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !wrEn) |=> $stable(outLevel));

  // R2: a square-wave mode word parks the output high
  p_square_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && (wrData[2:1] == 2'b11)) |=> outLevel);

  // R6: a one-shot mode word parks the output low
  p_oneshot_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && (wrData[2:1] != 2'b11)) |=> !outLevel);

endmodule

bind pit_channel pit_channel_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .cntEn(cntEn), .addr(addr), .wrEn(wrEn),
  .wrData(wrData), .outLevel(outLevel), .tickIrq(tickIrq)
);

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;

  logic       clk = 1'b0, rstN = 1'b0, cntEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       outLevel, tickIrq;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pit_channel dut_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .outLevel(outLevel), .tickIrq(tickIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); addr = 2'd0; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic readStatus(output logic [7:0] s);
    wr(2'd3, 8'hE2);
    rd(s);
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk); cntEn = 1'b1;
      @(negedge clk); cntEn = 1'b0;
    end
  endtask

  // runs enabled steps (every gap-th edge) until the output rises
  task automatic measureRise(input int gap, input int lim, output int riseK, output logic tickSeen);
    riseK = -1; tickSeen = 1'b0;
    for (int k = 1; k <= lim; k++) begin
      cntEn = ((k - 1) % gap == 0);
      @(negedge clk);
      if (outLevel) begin riseK = k; tickSeen = tickIrq; break; end
    end
    cntEn = 1'b0;
  endtask

  task automatic oneShotCase(input string tag, input int gap, input int expK, input int lim);
    int k; logic t;
    measureRise(gap, lim, k, t);
    check({tag, " rise step"}, k, expK);
    check({"R8 tick at one-shot rise ", tag}, t, 1);
    step(3);
    check({"R6 output stays high ", tag}, outLevel, 1);
    check({"R8 no tick after rise ", tag}, tickIrq, 0);
  endtask

  task automatic waitTick(input int lim, output int k);
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      cntEn = 1'b1;
      @(negedge clk);
      if (tickIrq) begin k = i; break; end
    end
    cntEn = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R5 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int k, hi, lo;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset outLevel", outLevel, 0);
    check("R1 reset tickIrq", tickIrq, 0);
    readStatus(b);
    check("R1 R14 reset status", b, 8'h70);

    // one-shot, full-range count, latch behaviour
    wr(2'd3, 8'h30); wr(2'd0, 8'hFF); wr(2'd0, 8'hFF);
    readStatus(b);
    check("R4 null set before load", b, 8'h70);
    step(1);
    readStatus(b);
    check("R4 R14 null clear after load", b, 8'h30);
    wr(2'd3, 8'hC2);
    rd(b); check("R10 status first", b, 8'h30);
    rd(b); check("R10 count low", b, 8'hFF);
    rd(b); check("R10 count high", b, 8'hFF);
    step(1);
    wr(2'd3, 8'h00);
    rd(b); check("R12 latch low", b, 8'hFE);
    rd(b); check("R12 latch high", b, 8'hFF);
    wr(2'd3, 8'hD2);
    step(3);
    wr(2'd3, 8'hD2);
    rd(b); check("R11 R10 held low byte", b, 8'hFE);
    rd(b); check("R11 held high byte", b, 8'hFF);
    rd(b); check("R13 live low", b, 8'hFB);
    rd(b); check("R13 live high", b, 8'hFF);

    // one-shot sweep, N = 1..6
    for (int n = 1; n <= 6; n++) begin
      wr(2'd3, 8'h30); wr(2'd0, 8'(n)); wr(2'd0, 8'h00);
      check("R2 one-shot word output low", outLevel, 0);
      oneShotCase($sformatf("R6 N=%0d", n), 1, n + 1, 100);
    end
    // gated counting
    wr(2'd3, 8'h30); wr(2'd0, 8'd4); wr(2'd0, 8'h00);
    oneShotCase("R5 gated N=4", 2, 9, 100);
    // low-only access
    wr(2'd3, 8'h10); wr(2'd0, 8'd3);
    readStatus(b);
    check("R3 R14 low-only status", b, 8'h50);
    oneShotCase("R3 low-only N=3", 1, 4, 100);
    // high-only access
    wr(2'd3, 8'h20); wr(2'd0, 8'd1);
    oneShotCase("R3 high-only N=256", 1, 257, 400);
    // zero means full range
    wr(2'd3, 8'h30); wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    oneShotCase("R3 zero N=65536", 1, 65537, 70000);

    // square-wave sweep
    for (int n = 2; n <= 12; n++) begin
      wr(2'd3, 8'h36);
      check("R2 square word output high", outLevel, 1);
      if (n == 2) begin
        readStatus(b);
        check("R14 square status", b, 8'hF6);
      end
      wr(2'd0, 8'(n)); wr(2'd0, 8'h00);
      waitTick(100, k);
      check($sformatf("R7 first tick N=%0d", n), k, n + 1);
      hi = 1; lo = 0;
      for (int i = 0; i < 100; i++) begin
        cntEn = 1'b1;
        @(negedge clk);
        if (tickIrq) break;
        if (outLevel) hi++; else lo++;
      end
      cntEn = 1'b0;
      check($sformatf("R7 high steps N=%0d", n), hi, (n + 1) / 2);
      check($sformatf("R7 low steps N=%0d", n), lo, n / 2);
    end

    // deferred reload in square-wave mode
    wr(2'd3, 8'h36); wr(2'd0, 8'd8); wr(2'd0, 8'h00);
    waitTick(100, k);
    wr(2'd0, 8'd4); wr(2'd0, 8'h00);
    readStatus(b);
    check("R4 R9 null set while pending", b, 8'hF6);
    waitTick(100, k);
    check("R9 old period completes", k, 8);
    waitTick(100, k);
    check("R9 new period length", k, 4);
    readStatus(b);
    check("R4 R9 null clear after reload", b, 8'hB6);
    wr(2'd3, 8'h76);
    readStatus(b);
    check("R2 other channel word ignored", b, 8'hB6);
    check("R2 other channel output", outLevel, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule